// File: doc/BRIEF.md
# Page-Mode EEPROM Write Front End

This block is a clock-domain model of the write side of a byte-wide, page-mode non-volatile memory. Asynchronous active-low strobes (chip select, write enable, output enable) pass through a synchronizer and a glitch filter. Address and data are delayed to stay aligned with the strobes. A write pulse is qualified when both strobes are low, output enable is high, supply power has settled and no internal write is in progress. The address is latched where the pulse begins and the data where it ends. Accepted bytes go into a page buffer, and every byte must target the same page.

A retriggerable load window stays open while bytes keep arriving. When the window lapses with at least one byte loaded, the block enters a busy period of fixed length. During that period a polling read returns the last byte with its top bit inverted. When the busy period ends, the read returns the byte unchanged. The buffer can be read back by offset, so the storage array downstream can take the page.

Top module: `eeprom_page_loader`

## Requirements
- R1: After reset, busy_o, load_open_o, page_err_o, count_o and poll_o are all zero.
- R2: While pwr_good_i is low, and for POWERUP_CYC cycles after its synchronized rise, every strobe is ignored: no window opens and no byte is stored.
- R3: While oe_n_i is low, a strobe pulse opens no window and stores no byte.
- R4: A strobe low for fewer than GLITCH_CYC synchronized samples does nothing.
- R5: A write pulse shorter than MIN_PULSE_CYC qualified cycles stores no byte.
- R6: The address comes from the moment the later of cs_n_i and we_n_i falls. The data comes from the moment the earlier of the two rises. Either strobe may lead.
- R7: Each filtered fall of write enable, and each stored byte, restarts the load window. busy_o rises WINDOW_CYC cycles after the last such event, within the synchronizer and filter latency, and only if at least one byte is held.
- R8: busy_o stays high for exactly WRITE_CYC cycles. During that time load_open_o is low, and strobes change neither count_o nor buffer contents.
- R9: The page field, addr bits above PAGE_W, is locked by the first byte and reported on page_o. A byte for another page is dropped and sets page_err_o, which stays set until reset.
- R10: poll_o equals the last stored byte with its MSB inverted while busy_o is high, and the true byte otherwise.
- R11: count_o counts distinct offsets loaded (up to 2**PAGE_W). Rewriting an offset replaces its data without counting again. rd_data_o and rd_valid_o give the byte and loaded flag at rd_off_i. The first byte of a new page clears all other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Supply-settled level, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | DATA_W | Write data |
| rd_off_i | input | PAGE_W | Buffer read offset |
| rd_data_o | output | DATA_W | Buffer byte at rd_off_i |
| rd_valid_o | output | 1 | Offset loaded in current page |
| load_open_o | output | 1 | Load window running |
| busy_o | output | 1 | Internal write period |
| page_o | output | ADDR_W-PAGE_W | Locked page field |
| count_o | output | PAGE_W+1 | Distinct bytes loaded |
| poll_o | output | DATA_W | Status read value |
| page_err_o | output | 1 | Sticky wrong-page flag |

## Verification
The assertions assume that address and data stay stable across the synchronizer and filter delay around each strobe edge, which means several clock cycles before and after. They also assume reset is held until the clocks are settled. The stimulus changes address and data only at the negative clock edge, and at least two cycles before the edge they belong to. Where a test deliberately changes them during a pulse, it does so well past the filter latency. Every pulse is kept short, long, or clearly between the glitch and minimum-width limits, so that no check depends on a single cycle of filter timing.

// File: rtl/epl_pkg.sv
// Shared types of the page-write front end.
package epl_pkg;
    // Sequencing of the load window and the internal write period.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_BUSY = 2'd2
    } epl_state_e;
endpackage

// File: rtl/epl_strobe_filter.sv
// Synchronizes N active-low strobes and reports each one as asserted only
// after GLITCH_CYC consecutive low samples; release is immediate.
// Assumes SYNC_STAGES >= 2 and GLITCH_CYC >= 1.
module epl_strobe_filter #(
    parameter int N           = 3,
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_CYC  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] low_q
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(GLITCH_CYC);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] sync_q;
        logic [CW-1:0]          cnt_q;

        // Bring the strobe into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n[g]};
        end

        // Count consecutive low samples, saturating at the filter length.
        always_ff @(posedge clk) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (sync_q[SYNC_STAGES-1])  cnt_q <= '0;
            else if (cnt_q != CMAX)          cnt_q <= cnt_q + 1'b1;
        end

        assign low_q[g] = (cnt_q == CMAX);
    end
endmodule

// File: rtl/epl_power_gate.sv
// Turns the asynchronous supply-settled level into a write permission that
// rises HOLD_CYC cycles after the synchronized level and drops at once.
module epl_power_gate #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_i,
    output logic allow_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HMAX = HW'(HOLD_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HW-1:0]          hold_q;

    // Synchronize the supply level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pwr_i};
    end

    // Run the hold-off counter; permission only after it completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_q[SYNC_STAGES-1]) begin
            hold_q  <= '0;
            allow_o <= 1'b0;
        end else if (hold_q == HMAX) begin
            allow_o <= 1'b1;
        end else begin
            hold_q  <= hold_q + 1'b1;
        end
    end
endmodule

// File: rtl/epl_page_buffer.sv
// One page of byte storage with a per-offset loaded flag and a count of
// distinct offsets. A write marked new_page discards all earlier flags.
module epl_page_buffer #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              new_page,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [PAGE_W:0]   count
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  mask_q;

    // Store the byte; contents need no reset because flags qualify them.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_off] <= wr_data;
    end

    // Track loaded offsets and their number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            count  <= '0;
        end else if (wr_en && new_page) begin
            mask_q <= DEPTH'(1) << wr_off;
            count  <= (PAGE_W+1)'(1);
        end else if (wr_en && !mask_q[wr_off]) begin
            mask_q[wr_off] <= 1'b1;
            count          <= count + 1'b1;
        end
    end

    assign rd_data  = mem_q[rd_off];
    assign rd_valid = mask_q[rd_off];
endmodule

// File: rtl/eeprom_page_loader.sv
// Write front end of a page-mode byte EEPROM: qualifies strobes, latches
// address at pulse start and data at pulse end, fills a one-page buffer
// under a retriggerable load window, then runs a fixed busy period with
// inverted-MSB polling. Assumes address and data are stable for several
// cycles around strobe edges.
module eeprom_page_loader #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int GLITCH_CYC  = 2,
    parameter int MIN_PULSE   = 38,
    parameter int WINDOW_CYC  = 37500,
    parameter int WRITE_CYC   = 2500000,
    parameter int POWERUP_CYC = 1250000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_good_i,
    input  logic                     cs_n_i,
    input  logic                     we_n_i,
    input  logic                     oe_n_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        din_i,
    input  logic [PAGE_W-1:0]        rd_off_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic                     rd_valid_o,
    output logic                     load_open_o,
    output logic                     busy_o,
    output logic [ADDR_W-PAGE_W-1:0] page_o,
    output logic [PAGE_W:0]          count_o,
    output logic [DATA_W-1:0]        poll_o,
    output logic                     page_err_o
);
    import epl_pkg::*;

    localparam int PW  = ADDR_W + DATA_W;
    localparam int PCW = $clog2(MIN_PULSE + 1);
    localparam int WNW = $clog2(WINDOW_CYC + 1);
    localparam int WRW = $clog2(WRITE_CYC + 1);
    localparam logic [PCW-1:0] PULSE_MIN = PCW'(MIN_PULSE);
    localparam logic [WNW-1:0] WIN_LAST  = WNW'(WINDOW_CYC - 1);
    localparam logic [WRW-1:0] WR_LAST   = WRW'(WRITE_CYC - 1);

    logic [2:0]  low_f;
    logic        cs_low, we_low, oe_high, allow;
    logic [PW-1:0] pipe_q [SYNC_STAGES];
    logic [ADDR_W-1:0] cur_addr, lat_addr;
    logic [DATA_W-1:0] cur_data, last_q;
    logic        active, active_q, we_low_q, we_fall;
    logic [PCW-1:0] pulse_q;
    logic        accept, page_hit, store, page_open;
    epl_state_e  state_q;
    logic [WNW-1:0] win_q;
    logic [WRW-1:0] wr_q;

    epl_strobe_filter #(.N(3), .SYNC_STAGES(SYNC_STAGES), .GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_n({oe_n_i, we_n_i, cs_n_i}), .low_q(low_f)
    );

    epl_power_gate #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(POWERUP_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .pwr_i(pwr_good_i), .allow_o(allow)
    );

    assign cs_low  = low_f[0];
    assign we_low  = low_f[1];
    assign oe_high = !low_f[2];

    // Delay address and data by the synchronizer depth to match strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= {addr_i, din_i};
            for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign cur_addr = pipe_q[SYNC_STAGES-1][PW-1:DATA_W];
    assign cur_data = pipe_q[SYNC_STAGES-1][DATA_W-1:0];

    // Qualification of a write pulse and of a window trigger.
    assign active  = cs_low && we_low && oe_high && allow && (state_q != ST_BUSY);
    assign we_fall = we_low && !we_low_q && oe_high && allow && (state_q != ST_BUSY);
    assign accept  = active_q && !active && oe_high && allow &&
                     (state_q != ST_BUSY) && (pulse_q >= PULSE_MIN);
    assign page_hit = !page_open || (lat_addr[ADDR_W-1:PAGE_W] == page_o);
    assign store    = accept && page_hit;

    // Edge history, pulse width and address latch at pulse start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            we_low_q <= 1'b0;
            pulse_q  <= '0;
            lat_addr <= '0;
        end else begin
            active_q <= active;
            we_low_q <= we_low;
            if (active && !active_q) begin
                pulse_q  <= PCW'(1);
                lat_addr <= cur_addr;
            end else if (active && pulse_q != PULSE_MIN) begin
                pulse_q  <= pulse_q + 1'b1;
            end
        end
    end

    // Page lock, last byte and sticky wrong-page flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_o     <= '0;
            last_q     <= '0;
            page_err_o <= 1'b0;
        end else begin
            if (store && !page_open) page_o <= lat_addr[ADDR_W-1:PAGE_W];
            if (store)               last_q <= cur_data;
            if (accept && !page_hit) page_err_o <= 1'b1;
        end
    end

    // Load window, busy period and page-open bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            win_q     <= '0;
            wr_q      <= '0;
            page_open <= 1'b0;
        end else begin
            if (store) page_open <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (we_fall || store) begin
                        state_q <= ST_LOAD;
                        win_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (we_fall || store) begin
                        win_q <= '0;
                    end else if (win_q >= WIN_LAST) begin
                        if (!active) begin
                            state_q <= page_open ? ST_BUSY : ST_IDLE;
                            wr_q    <= '0;
                        end
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (wr_q == WR_LAST) begin
                        state_q   <= ST_IDLE;
                        page_open <= 1'b0;
                    end else begin
                        wr_q <= wr_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    epl_page_buffer #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(store), .new_page(!page_open),
        .wr_off(lat_addr[PAGE_W-1:0]), .wr_data(cur_data),
        .rd_off(rd_off_i), .rd_data(rd_data_o), .rd_valid(rd_valid_o), .count(count_o)
    );

    assign busy_o      = (state_q == ST_BUSY);
    assign load_open_o = (state_q == ST_LOAD);
    assign poll_o      = busy_o ? {~last_q[DATA_W-1], last_q[DATA_W-2:0]} : last_q;
endmodule

// File: rtl/epl_checker.sv
// Temporal checks on the page loader's outputs, bound to every instance.
module epl_checker #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              load_open_o,
    input logic [PAGE_W:0]   count_o,
    input logic [DATA_W-1:0] poll_o,
    input logic              page_err_o
);
    localparam logic [PAGE_W:0] FULL = {1'b1, {PAGE_W{1'b0}}};

    AST_BUSY_EXCLUDES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_open_o); // R8
    AST_COUNT_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(count_o))); // R8
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        page_err_o |=> page_err_o); // R9
    AST_POLL_FLIP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (poll_o[DATA_W-1] != $past(poll_o[DATA_W-1]))); // R10
    AST_BUSY_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (count_o != '0)); // R7
endmodule

bind eeprom_page_loader epl_checker #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .load_open_o(load_open_o),
    .count_o(count_o), .poll_o(poll_o), .page_err_o(page_err_o)
);

// File: tb/tb_eeprom_page_loader.sv
`timescale 1ns/1ps
module tb_eeprom_page_loader;
    localparam int AW = 8, DW = 8, PG = 3;
    localparam int GL = 3, MP = 6, WIN = 60, WRC = 100, PUP = 40;

    logic clk = 0, rst_n = 0, pwr = 0, cs_n = 1, we_n = 1, oe_n = 1;
    logic [AW-1:0] addr = 0;
    logic [DW-1:0] din = 0;
    logic [PG-1:0] rd_off = 0;
    logic [DW-1:0] rd_data, poll;
    logic rd_valid, load_open, busy, perr;
    logic [AW-PG-1:0] page;
    logic [PG:0] count;
    int checks = 0, errors = 0;
    logic busy_seen = 0, open_seen = 0;

    always #2 clk = ~clk;

    eeprom_page_loader #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PG), .SYNC_STAGES(2),
        .GLITCH_CYC(GL), .MIN_PULSE(MP), .WINDOW_CYC(WIN), .WRITE_CYC(WRC),
        .POWERUP_CYC(PUP)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr), .cs_n_i(cs_n), .we_n_i(we_n),
        .oe_n_i(oe_n), .addr_i(addr), .din_i(din), .rd_off_i(rd_off),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .load_open_o(load_open),
        .busy_o(busy), .page_o(page), .count_o(count), .poll_o(poll), .page_err_o(perr));

    always @(negedge clk) begin
        #1;
        if (busy) busy_seen = 1;
        if (load_open) open_seen = 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [PG-1:0] off, input string req,
                      input logic v, input logic [DW-1:0] d);
        rd_off = off;
        #1;
        check(req, {31'd0, rd_valid}, {31'd0, v});
        if (v) check(req, {24'd0, rd_data}, {24'd0, d});
    endtask

    // Write pulse with both strobes together; oe_lvl drives oe_n during it.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int low, input logic oe_lvl);
        @(negedge clk);
        addr = a; din = d; oe_n = oe_lvl;
        tick(2);
        cs_n = 0; we_n = 0;
        tick(low);
        cs_n = 1; we_n = 1;
        tick(4);
        oe_n = 1;
        tick(4);
    endtask

    function automatic logic [DW-1:0] pat(input int off);
        return DW'(off * 37 + 11);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t;
        tick(4);
        rst_n = 1;
        tick(1);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 open", {31'd0, load_open}, 0);
        check("R1 err", {31'd0, perr}, 0);
        check("R1 count", {28'd0, count}, 0);
        check("R1 poll", {24'd0, poll}, 0);

        // R2 no power, then within hold-off
        open_seen = 0;
        wr(8'h10, 8'h01, 16, 1'b1);
        check("R2 nopower open", {31'd0, open_seen}, 0);
        pwr = 1;
        wr(8'h10, 8'h01, 16, 1'b1);
        check("R2 holdoff open", {31'd0, open_seen}, 0);
        check("R2 holdoff count", {28'd0, count}, 0);
        tick(PUP);

        // R3 output enable low inhibits
        wr(8'h10, 8'h02, 16, 1'b0);
        check("R3 open", {31'd0, open_seen}, 0);
        check("R3 count", {28'd0, count}, 0);

        // R4 glitch shorter than the filter
        wr(8'h10, 8'h03, 2, 1'b1);
        check("R4 open", {31'd0, open_seen}, 0);
        check("R4 count", {28'd0, count}, 0);

        // R5 pulse through the filter but under the minimum width
        busy_seen = 0;
        wr(8'h10, 8'h04, 6, 1'b1);
        check("R5 count", {28'd0, count}, 0);
        tick(WIN + WRC);
        check("R5 busy", {31'd0, busy_seen}, 0);
        check("R5 open closed", {31'd0, load_open}, 0);

        // R11/R9/R7 sweep a page of 8 offsets in page 5 with retriggers
        busy_seen = 0;
        for (int o = 0; o < 8; o++) wr({5'd5, 3'(o)}, pat(o), 16, 1'b1);
        wr({5'd5, 3'd2}, 8'hC3, 16, 1'b1);
        check("R11 count full", {28'd0, count}, 8);
        wr({5'd6, 3'd1}, 8'h77, 16, 1'b1);
        check("R9 err set", {31'd0, perr}, 1);
        check("R9 count kept", {28'd0, count}, 8);
        check("R9 page", {27'd0, page}, 5);
        check("R7 retrigger no busy", {31'd0, busy_seen}, 0);
        for (int o = 0; o < 8; o++) rd(3'(o), "R11 data", 1'b1, (o == 2) ? 8'hC3 : pat(o));

        t = 0;
        while (!busy && t < 200) begin tick(1); t++; end
        check("R7 busy reached", {31'd0, busy}, 1);
        check("R10 poll busy", {24'd0, poll}, 8'h43);
        // R8 write during busy is ignored
        wr({5'd5, 3'd0}, 8'hEE, 16, 1'b1);
        check("R8 no open in busy", {31'd0, load_open}, 0);
        t = 0;
        while (busy && t < 200) begin tick(1); t++; end
        tick(2);
        check("R8 count after", {28'd0, count}, 8);
        rd(3'd0, "R8 data kept", 1'b1, pat(0));
        check("R8 stays idle", {31'd0, load_open}, 0);
        check("R10 poll done", {24'd0, poll}, 8'hC3);
        check("R9 err sticky", {31'd0, perr}, 1);

        // R6 chip select leads; address at write-enable fall, data at its rise
        @(negedge clk);
        addr = {5'd9, 3'd6}; din = 8'h11; cs_n = 0;
        tick(8);
        addr = {5'd9, 3'd1};
        tick(2);
        we_n = 0;
        tick(10);
        addr = {5'd9, 3'd6};
        tick(2);
        din = 8'hA4;
        tick(4);
        we_n = 1;
        tick(4);
        din = 8'h22;
        cs_n = 1;
        tick(6);
        // R6 write enable leads; address at chip-select fall, data at its rise
        addr = {5'd9, 3'd4}; din = 8'h33; we_n = 0;
        tick(8);
        addr = {5'd9, 3'd3};
        tick(2);
        cs_n = 0;
        tick(10);
        addr = {5'd9, 3'd4};
        tick(2);
        din = 8'h5A;
        tick(4);
        cs_n = 1;
        t = 0;
        tick(4);
        din = 8'h44;
        we_n = 1;
        t = 4;
        check("R11 new page count", {28'd0, count}, 2);
        check("R9 new page", {27'd0, page}, 9);
        rd(3'd1, "R6 cs-lead", 1'b1, 8'hA4);
        rd(3'd3, "R6 we-lead", 1'b1, 8'h5A);
        rd(3'd6, "R6 no late addr", 1'b0, 8'h00);
        rd(3'd4, "R6 no early addr", 1'b0, 8'h00);
        rd(3'd0, "R11 old flag cleared", 1'b0, 8'h00);

        // R7 busy timing from the last capture; R8 exact busy length
        while (!busy && t < WIN + 40) begin tick(1); t++; end
        checks++;
        if (!(t >= WIN && t <= WIN + 8)) begin
            errors++;
            $display("FAIL R7 window actual %0d expected %0d..%0d", t, WIN, WIN + 8);
        end
        check("R10 poll busy low", {24'd0, poll}, 8'hDA);
        t = 0;
        while (busy && t < WRC + 50) begin tick(1); t++; end
        check("R8 busy length", t, WRC);
        check("R10 poll true", {24'd0, poll}, 8'h5A);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule